// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block produces the horizontal sync, vertical sync and data-enable waveforms for a parallel RGB TFT panel. It also produces a static output that selects which pixel-clock edge launches the data. Two counters step on a pixel-clock enable: a pixel counter along each line and a line counter down the frame. Each output is the result of comparing those counters against programmed windows. Every window is written as a pair of absolute counter positions packed into one 32-bit word, with the start in the upper half and the end in the lower half. Porch and pulse widths are not used.

Software writes the live timing words at any time. The block copies them into shadow registers only while scanning is stopped, or at the last pixel of a frame. A frame therefore never mixes two timings. One-clock strobes mark the first and last active pixel of every frame, so a frame fetcher or an interrupt source can follow the scan.

Top module: `lcd_sync_gen`

## Requirements
- R1: While `rstN` is low, every output is 0, and the pixel counter, line counter and shadow timing are cleared.
- R2: While `runEn` is high, the counters and the sync and data-enable outputs advance only on clocks where `pixEn` is high. On clocks with `pixEn` low, those outputs hold their value and the strobes are 0.
- R3: On each enabled step, the pixel counter counts 0 up to HT−1 and then returns to 0, and the line counter advances on that return. The line counter returns to 0 after VT−1. HT is bits 25:16 of `frameTotals` and VT is bits 9:0. Each output registers the state of the counters one clock after the step.
- R4: `hSync` is active while the pixel counter is at or above bits 25:16 and below bits 9:0 of `hSyncWin`. It is active high unless bit 11 of `polCfg` is set, in which case it is active low.
- R5: `vSync` is active while the line counter is at or above bits 25:16 and below bits 9:0 of `vSyncWin`. It is active low when bit 8 of `polCfg` is set.
- R6: `dataEn` is active only when the pixel counter lies in [`hActWin`[25:16], `hActWin`[9:0]) and the line counter lies in [`vActWin`[25:16], `vActWin`[9:0]). It is active low when bit 9 of `polCfg` is set.
- R7: `pclkFall` equals bit 10 of the shadow copy of `polCfg`.
- R8: `frameStart` is high for one clock, together with the output of the first active pixel of a frame (pixel = active-window start, line = active-window start).
- R9: `frameEnd` is high for one clock, together with the output of the last active pixel of a frame (pixel = active end − 1, line = active end − 1).
- R10: While scanning, a change to the live timing words or to `polCfg` has no effect until the first pixel of the next frame. The shadow copy is loaded on the step that wraps both counters.
- R11: While `runEn` is low, both counters are held at 0 and the strobes are 0. The sync and data-enable outputs sit at their inactive levels, and the shadow copy follows the live words on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | High to scan frames, low to idle |
| pixEn | input | 1 | Pixel-clock enable; one pixel per high clock |
| hSyncWin | input | 32 | Horizontal sync start (31:16) / end (15:0) |
| vSyncWin | input | 32 | Vertical sync start (31:16) / end (15:0) |
| hActWin | input | 32 | Active pixel window start (31:16) / end (15:0) |
| vActWin | input | 32 | Active line window start (31:16) / end (15:0) |
| frameTotals | input | 32 | Pixels per line (31:16), lines per frame (15:0) |
| polCfg | input | 32 | Polarity bits: 11 hSync low, 8 vSync low, 9 dataEn low, 10 falling edge |
| hSync | output | 1 | Horizontal sync |
| vSync | output | 1 | Vertical sync |
| dataEn | output | 1 | Data enable |
| pclkFall | output | 1 | Drive data on the falling pixel-clock edge |
| frameStart | output | 1 | First active pixel strobe |
| frameEnd | output | 1 | Last active pixel strobe |

## Verification
The strobe assertions assume that each active window is non-empty and lies inside the programmed totals. They also assume that the first and last active pixels never fall on the frame-wrap pixel, where the polarity could change on the same edge. The counter-range assertion assumes that a nonzero total is never smaller than the position the counter has reached. The bench keeps within these limits by using only two well-formed timings, each with proper porches on all four sides. It changes the timing only while idle or partway through a frame, never on the wrap step.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  // index of each timing word in the packed live-register bundle
  localparam int IDX_HSYNC = 0;
  localparam int IDX_VSYNC = 1;
  localparam int IDX_HACT  = 2;
  localparam int IDX_VACT  = 3;
  localparam int IDX_TOT   = 4;
  localparam int NREG      = 5;

  // polarity and edge bits of the configuration word
  localparam int POL_VS_LOW   = 8;
  localparam int POL_DE_LOW   = 9;
  localparam int POL_PCLK_NEG = 10;
  localparam int POL_HS_LOW   = 11;

  typedef struct packed {
    logic step;       // an enabled pixel step this clock
    logic lineWrap;   // pixel counter returns to 0 this step
    logic frameWrap;  // both counters return to 0 this step
    logic idle;       // scanning stopped
  } seqStrobeT;

endpackage

// File: rtl/lcd_sync_ctrl.sv
module lcd_sync_ctrl
  import lcd_sync_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             pixEn,
  input  logic [CNT_W-1:0] hTot,
  input  logic [CNT_W-1:0] vTot,
  output logic [CNT_W-1:0] hCnt,
  output logic [CNT_W-1:0] vCnt,
  output seqStrobeT        seq
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic atLineEnd;
  logic atFrameEnd;

  assign atLineEnd  = (hCnt == hTot - ONE);
  assign atFrameEnd = (vCnt == vTot - ONE);

  always_comb begin
    seq.idle      = !runEn;
    seq.step      = runEn && pixEn;
    seq.lineWrap  = seq.step && atLineEnd;
    seq.frameWrap = seq.lineWrap && atFrameEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (seq.idle) begin
      hCnt <= '0;
      vCnt <= '0;
    end else if (seq.step) begin
      if (atLineEnd) begin
        hCnt <= '0;
        vCnt <= atFrameEnd ? '0 : vCnt + ONE;
      end else begin
        hCnt <= hCnt + ONE;
      end
    end
  end

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (hCnt == '0 && vCnt == '0));

  // R2
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !pixEn) |=> ($stable(hCnt) && $stable(vCnt)));

  // R3
  hcnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && hTot != '0) |-> (hCnt < hTot));

endmodule

// File: rtl/lcd_sync_dp.sv
module lcd_sync_dp
  import lcd_sync_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int REG_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  seqStrobeT                  seq,
  input  logic [CNT_W-1:0]           hCnt,
  input  logic [CNT_W-1:0]           vCnt,
  input  logic [NREG-1:0][REG_W-1:0] liveRegs,
  input  logic [REG_W-1:0]           polCfg,
  output logic [CNT_W-1:0]           hTot,
  output logic [CNT_W-1:0]           vTot,
  output logic                       hSync,
  output logic                       vSync,
  output logic                       dataEn,
  output logic                       pclkFall,
  output logic                       frameStart,
  output logic                       frameEnd
);

  localparam int HALF_W = REG_W / 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [NREG-1:0][CNT_W-1:0] shHi;
  logic [NREG-1:0][CNT_W-1:0] shLo;
  logic shHsLow, shVsLow, shDeLow, shPclkNeg;
  logic loadShadow;
  logic unusedBits;

  assign loadShadow = seq.idle || seq.frameWrap;
  assign unusedBits = ^{liveRegs, polCfg};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shHi      <= '0;
      shLo      <= '0;
      shHsLow   <= 1'b0;
      shVsLow   <= 1'b0;
      shDeLow   <= 1'b0;
      shPclkNeg <= 1'b0;
    end else if (loadShadow) begin
      for (int i = 0; i < NREG; i++) begin
        shHi[i] <= liveRegs[i][HALF_W +: CNT_W];
        shLo[i] <= liveRegs[i][0 +: CNT_W];
      end
      shHsLow   <= polCfg[POL_HS_LOW];
      shVsLow   <= polCfg[POL_VS_LOW];
      shDeLow   <= polCfg[POL_DE_LOW];
      shPclkNeg <= polCfg[POL_PCLK_NEG];
    end
  end

  assign hTot     = shHi[IDX_TOT];
  assign vTot     = shLo[IDX_TOT];
  assign pclkFall = shPclkNeg;

  logic hSyncOn, vSyncOn, hActOn, vActOn, firstPix, lastPix;

  always_comb begin
    hSyncOn  = (hCnt >= shHi[IDX_HSYNC]) && (hCnt < shLo[IDX_HSYNC]);
    vSyncOn  = (vCnt >= shHi[IDX_VSYNC]) && (vCnt < shLo[IDX_VSYNC]);
    hActOn   = (hCnt >= shHi[IDX_HACT])  && (hCnt < shLo[IDX_HACT]);
    vActOn   = (vCnt >= shHi[IDX_VACT])  && (vCnt < shLo[IDX_VACT]);
    firstPix = hActOn && vActOn && (hCnt == shHi[IDX_HACT]) && (vCnt == shHi[IDX_VACT]);
    lastPix  = hActOn && vActOn && (hCnt == shLo[IDX_HACT] - ONE)
               && (vCnt == shLo[IDX_VACT] - ONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hSync      <= 1'b0;
      vSync      <= 1'b0;
      dataEn     <= 1'b0;
      frameStart <= 1'b0;
      frameEnd   <= 1'b0;
    end else if (seq.idle) begin
      hSync      <= shHsLow;
      vSync      <= shVsLow;
      dataEn     <= shDeLow;
      frameStart <= 1'b0;
      frameEnd   <= 1'b0;
    end else if (seq.step) begin
      hSync      <= hSyncOn ^ shHsLow;
      vSync      <= vSyncOn ^ shVsLow;
      dataEn     <= (hActOn && vActOn) ^ shDeLow;
      frameStart <= firstPix;
      frameEnd   <= lastPix;
    end else begin
      frameStart <= 1'b0;
      frameEnd   <= 1'b0;
    end
  end

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(seq.idle || seq.frameWrap) |=> ($stable(shHi) && $stable(shLo) && $stable(pclkFall)));

  // R8
  sof_in_de_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> (dataEn != shDeLow));

  // R9
  eof_in_de_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |-> (dataEn != shDeLow));

  // R2
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !seq.step |=> (!frameStart && !frameEnd));

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             pixEn,
  input  logic [REG_W-1:0] hSyncWin,
  input  logic [REG_W-1:0] vSyncWin,
  input  logic [REG_W-1:0] hActWin,
  input  logic [REG_W-1:0] vActWin,
  input  logic [REG_W-1:0] frameTotals,
  input  logic [REG_W-1:0] polCfg,
  output logic             hSync,
  output logic             vSync,
  output logic             dataEn,
  output logic             pclkFall,
  output logic             frameStart,
  output logic             frameEnd
);

  logic [NREG-1:0][REG_W-1:0] liveRegs;
  logic [CNT_W-1:0] hCnt, vCnt, hTot, vTot;
  seqStrobeT seq;

  always_comb begin
    liveRegs[IDX_HSYNC] = hSyncWin;
    liveRegs[IDX_VSYNC] = vSyncWin;
    liveRegs[IDX_HACT]  = hActWin;
    liveRegs[IDX_VACT]  = vActWin;
    liveRegs[IDX_TOT]   = frameTotals;
  end

  lcd_sync_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .pixEn(pixEn),
    .hTot(hTot), .vTot(vTot), .hCnt(hCnt), .vCnt(vCnt), .seq(seq)
  );

  lcd_sync_dp #(.CNT_W(CNT_W), .REG_W(REG_W)) uDp (
    .clk(clk), .rstN(rstN), .seq(seq), .hCnt(hCnt), .vCnt(vCnt),
    .liveRegs(liveRegs), .polCfg(polCfg), .hTot(hTot), .vTot(vTot),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn), .pclkFall(pclkFall),
    .frameStart(frameStart), .frameEnd(frameEnd)
  );

endmodule

// File: tb/sim_lcd_sync_gen.sv
`timescale 1ns/1ps
module sim_lcd_sync_gen;

  typedef struct packed {
    logic [31:0] hs, vs, ha, va, tot, pol;
  } cfgT;

  typedef struct packed {
    logic hs, vs, de, pf, sof, eof;
  } expT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic pixEn = 1'b0;
  logic [31:0] hSyncWin = '0, vSyncWin = '0, hActWin = '0, vActWin = '0;
  logic [31:0] frameTotals = '0, polCfg = '0;
  logic hSync, vSync, dataEn, pclkFall, frameStart, frameEnd;

  int checks = 0;
  int failures = 0;
  string phase = "R1";

  expT q[$];
  cfgT pend, sh;
  expT mo;
  int mh, mv;

  always #2.5 clk = ~clk;

  lcd_sync_gen u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .pixEn(pixEn),
    .hSyncWin(hSyncWin), .vSyncWin(vSyncWin), .hActWin(hActWin),
    .vActWin(vActWin), .frameTotals(frameTotals), .polCfg(polCfg),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn), .pclkFall(pclkFall),
    .frameStart(frameStart), .frameEnd(frameEnd)
  );

  function automatic cfgT mkCfg(int hse, int vse, int hds, int hde, int vds, int vde,
                                int ht, int vt, logic [31:0] pol);
    cfgT c;
    c.hs  = {16'd0, 16'(hse)};
    c.vs  = {16'd0, 16'(vse)};
    c.ha  = {16'(hds), 16'(hde)};
    c.va  = {16'(vds), 16'(vde)};
    c.tot = {16'(ht), 16'(vt)};
    c.pol = pol;
    return c;
  endfunction

  function automatic bit inw(int c, logic [31:0] r);
    return (c >= int'(r[25:16])) && (c < int'(r[9:0]));
  endfunction

  task automatic chk(logic got, logic exp, string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  // model one clock edge from the requirements and push the expected outputs
  task automatic modelEdge(bit r, bit e);
    expT o = mo;
    bit hOn, vOn;
    int ht, vt;
    if (!r) begin
      o.hs = sh.pol[11]; o.vs = sh.pol[8]; o.de = sh.pol[9];
      o.sof = 1'b0; o.eof = 1'b0;
      sh = pend; mh = 0; mv = 0;
    end else if (e) begin
      ht = int'(sh.tot[25:16]); vt = int'(sh.tot[9:0]);
      hOn = inw(mh, sh.ha); vOn = inw(mv, sh.va);
      o.hs = inw(mh, sh.hs) ^ sh.pol[11];
      o.vs = inw(mv, sh.vs) ^ sh.pol[8];
      o.de = (hOn && vOn) ^ sh.pol[9];
      o.sof = hOn && vOn && mh == int'(sh.ha[25:16]) && mv == int'(sh.va[25:16]);
      o.eof = hOn && vOn && mh == int'(sh.ha[9:0]) - 1 && mv == int'(sh.va[9:0]) - 1;
      if (mh == ht - 1) begin
        mh = 0;
        if (mv == vt - 1) begin mv = 0; sh = pend; end
        else mv++;
      end else mh++;
    end else begin
      o.sof = 1'b0; o.eof = 1'b0;
    end
    o.pf = sh.pol[10];
    mo = o;
    q.push_back(o);
  endtask

  // driver: applies inputs between edges, then queues what the next edge must produce
  task automatic step(bit r, bit e);
    @(posedge clk); #3;
    runEn = r; pixEn = e;
    hSyncWin = pend.hs; vSyncWin = pend.vs; hActWin = pend.ha;
    vActWin = pend.va; frameTotals = pend.tot; polCfg = pend.pol;
    modelEdge(r, e);
  endtask

  // monitor: compares each result as it appears
  initial begin
    expT ex;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        ex = q.pop_front();
        chk(hSync,      ex.hs,  {phase, " R4 hSync"});
        chk(vSync,      ex.vs,  {phase, " R5 vSync"});
        chk(dataEn,     ex.de,  {phase, " R6 dataEn"});
        chk(pclkFall,   ex.pf,  {phase, " R7 pclkFall"});
        chk(frameStart, ex.sof, {phase, " R8 frameStart"});
        chk(frameEnd,   ex.eof, {phase, " R9 frameEnd"});
      end
    end
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cfgT cfgA, cfgB;
    // A: 12x6 frame, 6x3 active, all active high, rising edge
    cfgA = mkCfg(2, 1, 3, 9, 2, 5, 12, 6, 32'h0);
    // B: 10x5 frame, 4x2 active, every polarity bit set
    cfgB = mkCfg(3, 2, 4, 8, 2, 4, 10, 5, 32'h0000_0F00);
    sh = '0; mo = '0; mh = 0; mv = 0; pend = '0;

    repeat (4) @(posedge clk);
    #2;
    // R1: reset state
    chk(hSync, 1'b0, "R1 hSync"); chk(vSync, 1'b0, "R1 vSync");
    chk(dataEn, 1'b0, "R1 dataEn"); chk(pclkFall, 1'b0, "R1 pclkFall");
    chk(frameStart, 1'b0, "R1 frameStart"); chk(frameEnd, 1'b0, "R1 frameEnd");
    @(posedge clk); #3;
    rstN = 1'b1;

    phase = "R11";
    pend = cfgA;
    repeat (3) step(1'b0, 1'b1);

    phase = "R3";
    repeat (2 * 72 + 5) step(1'b1, 1'b1);

    phase = "R2";
    for (int i = 0; i < 90; i++) step(1'b1, (i % 3) == 0);

    phase = "R11";
    pend = cfgB;
    repeat (4) step(1'b0, 1'b1);

    phase = "R10";
    repeat (20) step(1'b1, 1'b1);
    pend = cfgA;
    repeat (30 + 72 + 10) step(1'b1, 1'b1);

    repeat (3) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule